// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block models the write-side control of a byte-wide, page-organised flash part. A host reaches it over an asynchronous strobe bus: a 17-bit address, a data byte, and active-low chip select, read enable and write strobe. All of these are sampled in the block's clock domain. Writes only count once a short unlock sequence has been decoded. That sequence opens a page-load window, in which bytes are gathered into a page buffer. The window closes when no further byte arrives within a fixed gap. The buffered page is then committed during a timed internal program. A six-write sequence instead starts a timed erase of the whole array.

While an internal operation runs, reads do not return array data. They return a status byte: bit 7 is the complement of bit 7 of the last byte written, and bit 6 changes after every completed read. A third sequence switches reads to identification codes, and a fourth switches them back. The array has a reduced depth for simulation, and the program and erase times are cycle-count parameters.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, `dout_oe` is low while no read is asserted, every array byte reads FFh, and reads are in normal (non-identification) mode.
- R2: `dout_oe` is high exactly when `ce_n` and `oe_n` are both low. A normal read returns the array byte addressed by `addr[ARRAY_AW-1:0]`.
- R3: Writes of AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h open page loading. Command addresses compare `addr[14:0]` only. Data writes made without this prefix leave the array unchanged.
- R4: A write whose address or data does not match the next step of a sequence returns the decoder to idle. A byte written after such a break is not loaded.
- R5: A write counts only when `ce_n` and `we_n` are low and `oe_n` is high for at least GLITCH_CYC consecutive clocks. The count takes effect on the clock after the strobe ends, using the address and data present in its last active cycle. Shorter strobes, and strobes with `oe_n` low, are ignored.
- R6: The first load after unlocking fixes the page (`addr[ARRAY_AW-1:7]`). Each load stores its data at offset `addr[6:0]` of that page, and the page bits of later loads are ignored. Only the offsets that were loaded are replaced in the array.
- R7: Loading ends LOAD_TO_CYC clocks after the last accepted load. A load that takes effect on that very clock is kept and restarts the gap. If the gap expires with no load, the block returns to idle without any operation.
- R8: The program lasts PROG_CYC clocks. After it, reads return the newly loaded bytes.
- R9: Writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h erase the whole array to FFh over ERASE_CYC clocks.
- R10: During a program or erase, a read returns {~b7, t, 000000b}. Here b7 is bit 7 of the last accepted write, and t is 0 at the start of the operation and inverts after each read ends.
- R11: AAh@5555h, 55h@2AAAh, 90h@5555h enter identification mode. In this mode a read returns MFG_CODE when `addr[0]` is 0 and DEV_CODE when it is 1. AAh@5555h, 55h@2AAAh, F0h@5555h leave the mode.
- R12: Writes that take effect while a program or erase is running change neither the mode nor the sequence decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status |
| dout_oe | output | 1 | Data output driven (low models high impedance) |

## Verification
The end of the load gap and a late page load can land on the same clock. In that case the load must win and restart the gap. The bench provokes this by spacing the second load so that its strobe completes exactly LOAD_TO_CYC clocks after the first, and expects that byte in the array. It then spaces a third load one clock later and expects it to be dropped, because the program has already started and writes are ignored while busy.

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl #(
  parameter int ARRAY_AW = 8,
  parameter int PAGE_AW = 7,
  parameter int GLITCH_CYC = 3,
  parameter int LOAD_TO_CYC = 40,
  parameter int PROG_CYC = 100,
  parameter int ERASE_CYC = 200,
  parameter logic [7:0] MFG_CODE = 8'hDA,
  parameter logic [7:0] DEV_CODE = 8'hC1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [16:0] addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        dout_oe
);

  localparam int DEPTH = 1 << ARRAY_AW;
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int PG_W = ARRAY_AW - PAGE_AW;
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam int LW = $clog2(LOAD_TO_CYC + 1);
  localparam int OP_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int OW = $clog2(OP_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_E3, S_E4, S_E5, S_LOAD, S_PROG, S_ERASE
  } st_t;

  st_t st;
  logic [GW-1:0] wcnt;
  logic [14:0] lat_addr;
  logic [7:0] lat_din;
  logic [LW-1:0] ld_cnt;
  logic [OW-1:0] op_cnt;
  logic [PG_W-1:0] pg;
  logic [PAGE_BYTES-1:0] vld;
  logic [7:0] pbuf [PAGE_BYTES];
  logic [7:0] mem [DEPTH];
  logic id_mode, tog, last_d7, any_ld, rd_prev;

  logic wr_act, rd_act, wr_evt, rd_end, busy, a5555, a2aaa;
  logic unused_hi;

  assign unused_hi = ^addr[16:15];
  assign wr_act = !ce_n && !we_n && oe_n;
  assign rd_act = !ce_n && !oe_n;
  assign wr_evt = !wr_act && (wcnt >= GW'(GLITCH_CYC));
  assign rd_end = rd_prev && !rd_act;
  assign busy = (st == S_PROG) || (st == S_ERASE);
  assign a5555 = lat_addr == 15'h5555;
  assign a2aaa = lat_addr == 15'h2AAA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      lat_addr <= '0;
      lat_din <= '0;
      rd_prev <= 1'b0;
    end else begin
      rd_prev <= rd_act;
      if (wr_act) begin
        if (wcnt != GW'(GLITCH_CYC)) wcnt <= wcnt + 1'b1;
        lat_addr <= addr[14:0];
        lat_din <= din;
      end else begin
        wcnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      id_mode <= 1'b0;
      ld_cnt <= '0;
      op_cnt <= '0;
      tog <= 1'b0;
      last_d7 <= 1'b0;
      pg <= '0;
      vld <= '0;
      any_ld <= 1'b0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (busy && rd_end) tog <= ~tog;
      case (st)
        S_PROG, S_ERASE: begin
          if (op_cnt == '0) st <= S_IDLE;
          else op_cnt <= op_cnt - 1'b1;
        end
        S_LOAD: begin
          if (wr_evt) begin
            any_ld <= 1'b1;
            if (!any_ld) pg <= lat_addr[ARRAY_AW-1:PAGE_AW];
            pbuf[lat_addr[PAGE_AW-1:0]] <= lat_din;
            vld[lat_addr[PAGE_AW-1:0]] <= 1'b1;
            last_d7 <= lat_din[7];
            ld_cnt <= '0;
          end else if (ld_cnt == LW'(LOAD_TO_CYC - 1)) begin
            if (any_ld) begin
              st <= S_PROG;
              op_cnt <= OW'(PROG_CYC - 1);
              tog <= 1'b0;
              for (int i = 0; i < PAGE_BYTES; i++)
                if (vld[i]) mem[{pg, PAGE_AW'(i)}] <= pbuf[i];
            end else begin
              st <= S_IDLE;
            end
          end else begin
            ld_cnt <= ld_cnt + 1'b1;
          end
        end
        default: begin
          if (wr_evt) begin
            last_d7 <= lat_din[7];
            st <= S_IDLE;
            case (st)
              S_IDLE: if (a5555 && lat_din == 8'hAA) st <= S_U1;
              S_U1:   if (a2aaa && lat_din == 8'h55) st <= S_U2;
              S_U2: if (a5555) begin
                case (lat_din)
                  8'hA0: begin
                    st <= S_LOAD;
                    ld_cnt <= '0;
                    any_ld <= 1'b0;
                    vld <= '0;
                  end
                  8'h80: st <= S_E3;
                  8'h90: id_mode <= 1'b1;
                  8'hF0: id_mode <= 1'b0;
                  default: st <= S_IDLE;
                endcase
              end
              S_E3: if (a5555 && lat_din == 8'hAA) st <= S_E4;
              S_E4: if (a2aaa && lat_din == 8'h55) st <= S_E5;
              S_E5: if (a5555 && lat_din == 8'h10) begin
                st <= S_ERASE;
                op_cnt <= OW'(ERASE_CYC - 1);
                tog <= 1'b0;
                for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
              end
              default: st <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign dout_oe = rd_act;

  always_comb begin
    if (busy) dout = {~last_d7, tog, 6'b000000};
    else if (id_mode) dout = addr[0] ? DEV_CODE : MFG_CODE;
    else dout = mem[addr[ARRAY_AW-1:0]];
  end

  p_strobe_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> $past(wr_act));

  p_seq_break_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && (st == S_U1 || st == S_U2 || st == S_E3 || st == S_E4 || st == S_E5))
      |=> st != $past(st));

  p_gap_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD) |-> (ld_cnt < LW'(LOAD_TO_CYC)));

  p_op_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_cnt != '0) |=> busy);

  p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_end) |=> tog != $past(tog));

  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_evt) |=> ($stable(id_mode) && $stable(last_d7)));

endmodule

// File: tb/flash_seq_ctrl_tb.sv
module flash_seq_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int GL = 3;
  localparam int TO = 40;
  localparam int PC = 100;
  localparam int EC = 200;
  localparam logic [7:0] MFG = 8'hDA;
  localparam logic [7:0] DEV = 8'hC1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe;

  int n_tests = 0;
  int n_fail = 0;
  logic [7:0] expm [256];

  flash_seq_ctrl #(.ARRAY_AW(8), .PAGE_AW(7), .GLITCH_CYC(GL), .LOAD_TO_CYC(TO),
                   .PROG_CYC(PC), .ERASE_CYC(EC), .MFG_CODE(MFG), .DEV_CODE(DEV))
    dut_i (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
           .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe));

  initial forever #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input int h = GL,
                    input logic oe = 1'b1);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe;
    repeat (h) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] v, output logic oe_o);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #(CLK_P/4);
    v = dout; oe_o = dout_oe;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock();
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
  endtask

  task automatic settle();
    repeat (TO + PC + 10) @(negedge clk);
  endtask

  task automatic verify_all(input string tag);
    logic [7:0] v; logic o;
    for (int i = 0; i < 256; i++) begin
      rd(17'(i), v, o);
      chk(tag, v, expm[i]);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [16:0] a, input logic [7:0] e);
    logic [7:0] v; logic o;
    rd(a, v, o);
    chk(tag, v, e);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v; logic o; logic [7:0] lastd;
    for (int i = 0; i < 256; i++) expm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: output enable gating and erased array after reset
    #1 chk("R1 oe idle", {7'd0, dout_oe}, 8'd0);
    @(negedge clk); ce_n = 1'b0; #1 chk("R2 oe ce only", {7'd0, dout_oe}, 8'd0);
    ce_n = 1'b1; oe_n = 1'b0; #1 chk("R2 oe oe only", {7'd0, dout_oe}, 8'd0);
    oe_n = 1'b1;
    rd(17'h0, v, o); chk("R2 oe read", {7'd0, o}, 8'd1);
    verify_all("R1 erased after reset");

    // R3: unprotected write has no effect
    wr(17'h00010, 8'h33);
    settle();
    rd_chk("R3 unprotected", 17'h10, expm[8'h10]);

    // R6/R8/R10/R12: full page 1 program
    unlock();
    for (int i = 0; i < 128; i++) begin
      lastd = 8'((i * 7 + 3) & 255);
      wr(17'h80 + 17'(i), lastd);
      expm[128 + i] = lastd;
    end
    repeat (TO + 4) @(negedge clk);
    rd_chk("R10 poll 1", 17'h80, {~lastd[7], 1'b0, 6'd0});
    rd_chk("R10 poll 2", 17'h80, {~lastd[7], 1'b1, 6'd0});
    rd_chk("R10 poll 3", 17'h80, {~lastd[7], 1'b0, 6'd0});
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h90);
    repeat (PC + 10) @(negedge clk);
    rd_chk("R12 id entry ignored while busy", 17'h0, expm[0]);
    verify_all("R8 page program");

    // R6: page bits of later loads ignored
    unlock();
    wr(17'h00005, 8'h11); wr(17'h0008A, 8'h22);
    expm[8'h05] = 8'h11; expm[8'h0A] = 8'h22;
    settle();
    rd_chk("R6 first load", 17'h05, 8'h11);
    rd_chk("R6 redirected load", 17'h0A, 8'h22);
    rd_chk("R6 other page intact", 17'h8A, expm[8'h8A]);

    // R4: sequence breaks
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h56); wr(17'h05555, 8'hA0); wr(17'h20, 8'h44);
    settle(); rd_chk("R4 bad data step2", 17'h20, 8'hFF);
    wr(17'h05555, 8'hAA); wr(17'h02AAB, 8'h55); wr(17'h05555, 8'hA0); wr(17'h20, 8'h44);
    settle(); rd_chk("R4 bad addr step2", 17'h20, 8'hFF);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA1); wr(17'h20, 8'h44);
    settle(); rd_chk("R4 bad data step3", 17'h20, 8'hFF);
    wr(17'h01555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0); wr(17'h20, 8'h44);
    settle(); rd_chk("R4 bad addr step1", 17'h20, 8'hFF);

    // R3: upper address bits not compared
    wr(17'h15555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h1D555, 8'hA0); wr(17'h23, 8'h77);
    expm[8'h23] = 8'h77;
    settle(); rd_chk("R3 high bits ignored", 17'h23, 8'h77);

    // R5: glitch filter and read-enable inhibit
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55, GL - 1); wr(17'h05555, 8'hA0); wr(17'h21, 8'h66);
    settle(); rd_chk("R5 short strobe", 17'h21, 8'hFF);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55, GL, 1'b0); wr(17'h05555, 8'hA0); wr(17'h21, 8'h66);
    settle(); rd_chk("R5 oe low inhibit", 17'h21, 8'hFF);
    wr(17'h05555, 8'hAA, GL); wr(17'h02AAA, 8'h55, GL); wr(17'h05555, 8'hA0, GL); wr(17'h22, 8'h5A, GL);
    expm[8'h22] = 8'h5A;
    settle(); rd_chk("R5 minimum strobe", 17'h22, 8'h5A);

    // R7: load on the timeout clock wins; next one is too late
    unlock();
    wr(17'h30, 8'h01);
    repeat (TO - GL - 1) @(negedge clk);
    wr(17'h31, 8'h02);
    repeat (TO - GL) @(negedge clk);
    wr(17'h32, 8'h03);
    expm[8'h30] = 8'h01; expm[8'h31] = 8'h02;
    settle();
    rd_chk("R7 first load", 17'h30, 8'h01);
    rd_chk("R7 load on timeout clock", 17'h31, 8'h02);
    rd_chk("R7 late load dropped", 17'h32, 8'hFF);
    unlock();
    repeat (TO + 5) @(negedge clk);
    rd_chk("R7 empty window no busy", 17'h30, 8'h01);
    wr(17'h33, 8'h09);
    settle(); rd_chk("R7 window closed", 17'h33, 8'hFF);

    // R11: identification mode
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h90);
    rd_chk("R11 mfg", 17'h0, MFG);
    rd_chk("R11 dev", 17'h1, DEV);
    rd_chk("R11 mfg hi", 17'h80, MFG);
    rd_chk("R11 dev hi", 17'h81, DEV);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hF0);
    rd_chk("R11 exit", 17'h30, 8'h01);

    // R9/R10: chip erase
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h10);
    rd_chk("R10 erase poll 1", 17'h0, 8'h80);
    rd_chk("R10 erase poll 2", 17'h0, 8'hC0);
    repeat (EC + 10) @(negedge clk);
    for (int i = 0; i < 256; i++) expm[i] = 8'hFF;
    verify_all("R9 chip erase");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule